// File: doc/BRIEF.md
# BCD Seven-Segment Latch and Decoder

This block turns one decimal digit, given as a 4-bit 8421-weighted code, into the seven lines that drive a segment display. A storage register in front of the decoder can either follow the incoming code or hold the last one captured. The display stays readable while the data source moves on to other work. The held code is decoded into segment patterns. Codes that are not a decimal digit, and an explicit blank request, both turn every segment off.

A polarity input inverts all seven outputs after blanking. For an LCD, the same square wave drives this input and the panel's common backplane. A lit segment is then always in antiphase with the backplane, and a dark segment is always in phase with it. For LEDs the polarity input is tied to a constant level. Low suits common-cathode wiring and high suits common-anode wiring. Only the storage register is clocked. Decoding, blanking and inversion are a combinational path from the held code.

Top module: `bcd_seg7_driver`

## Requirements
- R1: While `rst` is high at a rising clock edge the held code becomes 0, so with `blank_req` and `phase_in` low `seg_out` reads 7'h3F after reset.
- R2: When `follow_en` is high at a rising edge, the held code takes the value of `bcd_in`, and `seg_out` shows that code from that edge on.
- R3: When `follow_en` is low at a rising edge, the held code does not change, whatever `bcd_in` does.
- R4: `seg_out` bit 0 is segment a and bit 6 is segment g. With phase low, codes 0 to 9 light these segments:
  - 0: a b c d e f
  - 1: b c
  - 2: a b d e g
  - 3: a b c d g
  - 4: b c f g
  - 5: a c d f g
  - 6: a c d e f g
  - 7: a b c
  - 8: all seven
  - 9: a b c d f g
- R5: A held code of 10 to 15 turns every segment off (`seg_out` = 7'h00 with phase low).
- R6: With `blank_req` high, every segment is off whatever the held code is.
- R7: With `phase_in` high, each of the seven outputs is the inverse of its phase-low value. A blank display therefore drives 7'h7F.
- R8: Changes on `blank_req` and `phase_in` reach `seg_out` without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the storage register |
| rst | input | 1 | Synchronous active-high reset, clears the held code |
| bcd_in | input | 4 | Digit code, 8421 weighting |
| follow_en | input | 1 | High: capture `bcd_in` each edge; low: hold |
| blank_req | input | 1 | High: all segments off |
| phase_in | input | 1 | High: invert all segment outputs |
| seg_out | output | 7 | Segment lines, bit 0 = a up to bit 6 = g |

## Verification
The bench walks all sixteen codes at both polarities. A wrong table entry shows up as a mis-lit digit. A missing illegal-code test shows up as stray glyphs on codes 10 to 15. Blanking is applied with valid data present and with phase high. If inversion were placed before blanking, a blank display would read 7'h00 instead of 7'h7F under phase high. The bench also moves `bcd_in` while the register is holding, so a hold that leaks through would change the digit. Finally it toggles `phase_in` mid-cycle, so an output that only updates on a clock edge would be caught.

// File: rtl/seg7_pkg.sv
package seg7_pkg;

    parameter int DIGIT_W   = 4;
    parameter int MAX_DIGIT = 9;

    // One bit per segment; a is the least significant bit.
    typedef struct packed {
        logic g;
        logic f;
        logic e;
        logic d;
        logic c;
        logic b;
        logic a;
    } seg_t;

    localparam int SEG_N = $bits(seg_t);

    typedef logic [DIGIT_W-1:0] digit_t;

    // Decoded glyph plus a flag telling whether the code is a decimal digit.
    typedef struct packed {
        logic legal;
        seg_t segs;
    } glyph_t;

    function automatic seg_t segs_of(input logic [SEG_N-1:0] bits);
        seg_t s;
        s = bits;
        return s;
    endfunction

    function automatic glyph_t glyph_of(input digit_t code);
        glyph_t gl;
        gl.legal = (int'(code) <= MAX_DIGIT);
        unique case (code)
            4'd0:    gl.segs = segs_of(7'b0111111);
            4'd1:    gl.segs = segs_of(7'b0000110);
            4'd2:    gl.segs = segs_of(7'b1011011);
            4'd3:    gl.segs = segs_of(7'b1001111);
            4'd4:    gl.segs = segs_of(7'b1100110);
            4'd5:    gl.segs = segs_of(7'b1101101);
            4'd6:    gl.segs = segs_of(7'b1111101);
            4'd7:    gl.segs = segs_of(7'b0000111);
            4'd8:    gl.segs = segs_of(7'b1111111);
            4'd9:    gl.segs = segs_of(7'b1101111);
            default: gl.segs = segs_of(7'b0000000);
        endcase
        return gl;
    endfunction

endpackage

// File: rtl/seg7_code_hold.sv
module seg7_code_hold
    import seg7_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   follow,
    input  digit_t code_in,
    output digit_t code_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
        end else if (follow) begin
            code_q <= code_in;
        end
    end

endmodule

// File: rtl/seg7_glyph_rom.sv
module seg7_glyph_rom
    import seg7_pkg::*;
(
    input  digit_t code,
    output glyph_t glyph
);

    always_comb begin
        glyph = glyph_of(code);
    end

endmodule

// File: rtl/seg7_drive_stage.sv
module seg7_drive_stage
    import seg7_pkg::*;
#(
    parameter int LINES = SEG_N
) (
    input  logic [LINES-1:0] raw,
    input  logic             legal,
    input  logic             blank,
    input  logic             phase,
    output logic [LINES-1:0] drive
);

    // Blanking is resolved first; polarity is applied last.
    logic dark;
    assign dark = blank | ~legal;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic lit;
        assign lit      = raw[i] & ~dark;
        assign drive[i] = lit ^ phase;
    end

endmodule

// File: rtl/bcd_seg7_driver.sv
module bcd_seg7_driver
    import seg7_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [DIGIT_W-1:0]  bcd_in,
    input  logic                follow_en,
    input  logic                blank_req,
    input  logic                phase_in,
    output logic [SEG_N-1:0]    seg_out
);

    digit_t held_q;
    glyph_t glyph;

    seg7_code_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .follow  (follow_en),
        .code_in (bcd_in),
        .code_q  (held_q)
    );

    seg7_glyph_rom u_rom (
        .code  (held_q),
        .glyph (glyph)
    );

    seg7_drive_stage #(.LINES(SEG_N)) u_drive (
        .raw   (glyph.segs),
        .legal (glyph.legal),
        .blank (blank_req),
        .phase (phase_in),
        .drive (seg_out)
    );

endmodule

// File: rtl/seg7_driver_checker.sv
module seg7_driver_checker
    import seg7_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [DIGIT_W-1:0] bcd_in,
    input logic               follow_en,
    input logic               blank_req,
    input logic               phase_in,
    input logic [DIGIT_W-1:0] held,
    input logic [SEG_N-1:0]   seg_out
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> held == '0);

    assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
        follow_en |=> held == $past(bcd_in));

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !follow_en |=> $stable(held));

    assert_illegal_dark_R5: assert property (@(posedge clk) disable iff (rst)
        (int'(held) > MAX_DIGIT && !phase_in) |-> seg_out == '0);

    assert_blank_dark_R6: assert property (@(posedge clk) disable iff (rst)
        (blank_req && !phase_in) |-> seg_out == '0);

    assert_blank_inverted_R7: assert property (@(posedge clk) disable iff (rst)
        (blank_req && phase_in) |-> seg_out == '1);

endmodule

bind bcd_seg7_driver seg7_driver_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bcd_in    (bcd_in),
    .follow_en (follow_en),
    .blank_req (blank_req),
    .phase_in  (phase_in),
    .held      (held_q),
    .seg_out   (seg_out)
);

// File: tb/sim_bcd_seg7_driver.sv
module sim_bcd_seg7_driver;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] bcd_in = 4'd0;
    logic       follow_en = 1'b0;
    logic       blank_req = 1'b0;
    logic       phase_in = 1'b0;
    logic [6:0] seg_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [6:0] exp_q[$];
    string      tag_q[$];
    logic [3:0] model_held = 4'd0;

    always #10 clk = ~clk;   // 50 MHz

    bcd_seg7_driver u0 (
        .clk       (clk),
        .rst       (rst),
        .bcd_in    (bcd_in),
        .follow_en (follow_en),
        .blank_req (blank_req),
        .phase_in  (phase_in),
        .seg_out   (seg_out)
    );

    // Expected phase-low pattern, bit 0 = a, bit 6 = g.
    function automatic logic [6:0] ref_glyph(input logic [3:0] c);
        case (c)
            4'd0: return 7'h3F;
            4'd1: return 7'h06;
            4'd2: return 7'h5B;
            4'd3: return 7'h4F;
            4'd4: return 7'h66;
            4'd5: return 7'h6D;
            4'd6: return 7'h7D;
            4'd7: return 7'h07;
            4'd8: return 7'h7F;
            4'd9: return 7'h6F;
            default: return 7'h00;
        endcase
    endfunction

    function automatic logic [6:0] ref_out(input logic [3:0] c, input logic bl, input logic ph);
        logic [6:0] v;
        v = bl ? 7'h00 : ref_glyph(c);
        return ph ? ~v : v;
    endfunction

    task automatic compare(input logic [6:0] exp, input string tag);
        checks++;
        if (seg_out !== exp) begin
            failures++;
            $display("FAIL %s: seg_out=%h expected=%h", tag, seg_out, exp);
        end
    endtask

    // Driver: one stimulus per cycle, expected value queued after the edge.
    task automatic apply(input logic [3:0] c, input logic fol, input logic bl,
                         input logic ph, input string tag);
        @(posedge clk);
        #5;
        bcd_in    = c;
        follow_en = fol;
        blank_req = bl;
        phase_in  = ph;
        @(posedge clk);
        if (fol) model_held = c;
        exp_q.push_back(ref_out(model_held, bl, ph));
        tag_q.push_back(tag);
    endtask

    // Monitor: samples mid-cycle.
    initial begin
        forever begin
            @(posedge clk);
            #12;
            if (exp_q.size() > 0) begin
                compare(exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        rst = 1'b0;
        #5;
        compare(7'h3F, "R1 reset shows digit 0");

        // R2 R4 R5 R7: every code at both polarities
        for (int ph = 0; ph < 2; ph++) begin
            for (int c = 0; c < 16; c++) begin
                apply(4'(c), 1'b1, 1'b0, 1'(ph),
                      (c > 9) ? "R5 illegal code dark (R7 phase)" : "R4 digit decode (R2 capture, R7 phase)");
            end
        end

        // R6 blanking overrides valid data, both phases
        apply(4'd8, 1'b1, 1'b1, 1'b0, "R6 blank over digit 8");
        apply(4'd3, 1'b1, 1'b1, 1'b1, "R7 blank with phase high");
        apply(4'd3, 1'b0, 1'b0, 1'b0, "R6 unblank shows held 3");

        // R3 hold: data moves while follow is low
        apply(4'd7, 1'b1, 1'b0, 1'b0, "R2 capture 7");
        for (int c = 0; c < 10; c++) begin
            apply(4'(c), 1'b0, 1'b0, 1'b0, "R3 hold keeps 7");
        end
        apply(4'd12, 1'b0, 1'b0, 1'b1, "R3 hold keeps 7 phase high");
        apply(4'd5, 1'b1, 1'b0, 1'b0, "R2 capture 5 after hold");

        // R8 combinational response to phase and blank
        while (exp_q.size() > 0) @(posedge clk);
        @(posedge clk);
        #3;
        phase_in = 1'b1;
        #2;
        compare(~7'h6D, "R8 phase change without edge");
        blank_req = 1'b1;
        #2;
        compare(7'h7F, "R8 blank change without edge");
        blank_req = 1'b0;
        phase_in  = 1'b0;
        #2;
        compare(7'h6D, "R8 release without edge");

        // R1 reset again from a non-zero held code
        @(posedge clk);
        #5;
        rst = 1'b1;
        @(posedge clk);
        #5;
        rst = 1'b0;
        #2;
        compare(7'h3F, "R1 second reset shows digit 0");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule